// File: doc/BRIEF.md
# Two-Stage Up/Down Decimation Counter with Digital CDS

This block is the digital back end of a first-order incremental delta-sigma converter that converts in two steps. In the first step the modulator emits a long coarse bitstream. In the second step it re-converts the residue left on its integrator into a short fine bitstream. The block counts the 1 bits of each stream in its own signed up/down segment. The coarse segment is weighted by the length of the fine stream, and the two segments are merged into one 12-bit two's-complement code.

Correlated double sampling is folded into the counting. The pixel reset level is converted first, with both segments counting down on every 1 bit. The signal level is then converted with both segments counting up. When the signal-phase fine stream is complete, the counters hold signal minus reset. A done flag marks that moment.

The bitstream arrives one bit per cycle, qualified by a valid strobe. The block never applies back-pressure, so there is no ready signal: every cycle with valid high is a bit offered to the counters. Stage select, phase select and clear are plain level controls that the sequencer holds steady around each bit.

Top module: `dsm_cds_decimator`

## Requirements
- R1: After reset is released, `result` reads 0, `done` reads 0 and `ovf_err` reads 0.
- R2: In the signal phase (`phase_sig`=1) of the coarse stage (`stage_fine`=0), each accepted 1 bit raises `result` by 32.
- R3: In the reset phase (`phase_sig`=0), each accepted 1 bit lowers the count of the selected segment. A coarse 1 bit lowers `result` by 32 and a fine 1 bit lowers it by 1.
- R4: In the signal phase of the fine stage (`stage_fine`=1), each accepted 1 bit raises `result` by 1.
- R5: A bit offered with `bit_valid` low leaves `result` unchanged, and so does a 0 bit offered with `bit_valid` high.
- R6: `result` is coarse_count*32 + fine_count in two's complement. Each count is signal 1 bits minus reset 1 bits for its stage. The value is clamped to the range -2048..2047.
- R7: `done` is high for exactly one cycle: the cycle after the 32nd valid fine-stage bit of the signal phase. It never rises at any other time.
- R8: Each (phase, stage) pair accepts at most 128 coarse or 32 fine valid bits. Any valid bit beyond that is not counted, and it sets `ovf_err` from the next cycle onward. `ovf_err` stays high until clear or reset.
- R9: `clr` is synchronous and takes precedence over a bit offered in the same cycle. On the next cycle `result` is 0 and `done` and `ovf_err` are low, and all bit tallies restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counts, tallies and flags |
| bit_valid | input | 1 | Qualifies `mod_bit` in this cycle |
| mod_bit | input | 1 | Modulator output bit |
| stage_fine | input | 1 | 0 = coarse stream, 1 = fine stream |
| phase_sig | input | 1 | 0 = reset-level conversion, 1 = signal-level conversion |
| result | output | 12 | Clamped signed CDS-corrected code |
| done | output | 1 | One-cycle pulse after the last signal-phase fine bit |
| ovf_err | output | 1 | Sticky flag: a stage received too many bits |

## Verification
The bench aims at the clamp edges. It uses codes that land exactly on 2047 and -2048 and codes one step beyond them. A design that wrapped instead of clamping would show a value of the opposite sign. The bench also probes the stream limits. It sends a 33rd fine bit and a 129th coarse bit, and a design that kept counting past the limit would read one step off and leave `ovf_err` low. Further cases cover a reset-phase fine stream that must not fire `done`, a clear that coincides with a valid 1 bit, and idle cycles with `mod_bit` held at 1. A design with the wrong priority or a missing valid qualifier would move `result` in those cases.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  typedef enum logic {PH_RST = 1'b0, PH_SIG = 1'b1} phase_e;
  typedef enum logic {ST_COARSE = 1'b0, ST_FINE = 1'b1} stage_e;

  // index of a (phase, stage) tally slot
  function automatic logic [1:0] slot_of(input logic ph, input logic st);
    return {ph, st};
  endfunction
endpackage

// File: rtl/updown_seg.sv
module updown_seg #(
  parameter int W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                step,
  input  logic                dir_up,
  output logic signed [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= dir_up ? count + W'(1) : count - W'(1);
  end

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(count));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && dir_up) |=> (count - $past(count)) == W'(1));
  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step && !dir_up) |=> ($past(count) - count) == W'(1));
endmodule

// File: rtl/bit_tally.sv
module bit_tally #(
  parameter int LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic full,
  output logic last_hit,
  output logic extra_hit
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] tally;

  assign full      = (tally == LIM);
  assign last_hit  = hit && (tally == LIM - TW'(1));
  assign extra_hit = hit && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             tally <= '0;
    else if (clr)           tally <= '0;
    else if (hit && !full)  tally <= tally + TW'(1);
  end

  // R8
  tally_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);
endmodule

// File: rtl/result_combine.sv
module result_combine #(
  parameter int CW    = 9,
  parameter int FW    = 7,
  parameter int SHIFT = 5,
  parameter int OUT_W = 12
) (
  input  logic signed [CW-1:0]    coarse,
  input  logic signed [FW-1:0]    fine,
  output logic signed [OUT_W-1:0] res
);
  localparam int SUM_W = ((CW + SHIFT > FW) ? CW + SHIFT : FW) + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(1 <<< (OUT_W - 1));

  logic signed [SUM_W-1:0] c_ext, f_ext, sum;

  always_comb begin
    c_ext = SUM_W'(coarse);
    f_ext = SUM_W'(fine);
    sum   = (c_ext <<< SHIFT) + f_ext;
    if (sum > MAXV)      res = OUT_W'(MAXV);
    else if (sum < MINV) res = OUT_W'(MINV);
    else                 res = OUT_W'(sum);
  end
endmodule

// File: rtl/dsm_cds_decimator.sv
module dsm_cds_decimator #(
  parameter int COARSE_N = 128,
  parameter int FINE_N   = 32,
  parameter int OUT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_valid,
  input  logic             mod_bit,
  input  logic             stage_fine,
  input  logic             phase_sig,
  output logic [OUT_W-1:0] result,
  output logic             done,
  output logic             ovf_err
);
  import dcd_pkg::*;

  localparam int CW    = $clog2(COARSE_N) + 2;
  localparam int FW    = $clog2(FINE_N) + 2;
  localparam int SHIFT = $clog2(FINE_N);

  logic [3:0] full_v, last_v, extra_v;
  logic [1:0] cur_slot;
  logic       step_c, step_f;
  logic signed [CW-1:0]    cnt_c;
  logic signed [FW-1:0]    cnt_f;
  logic signed [OUT_W-1:0] res_s;

  assign cur_slot = slot_of(phase_sig, stage_fine);

  for (genvar g = 0; g < 4; g++) begin : g_tally
    localparam int LIM = (g % 2 == 1) ? FINE_N : COARSE_N;
    logic hit;
    assign hit = bit_valid && (cur_slot == 2'(g));
    bit_tally #(.LIMIT(LIM)) u_tally (
      .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit),
      .full(full_v[g]), .last_hit(last_v[g]), .extra_hit(extra_v[g])
    );
  end

  assign step_c = bit_valid && mod_bit && (stage_fine == ST_COARSE) && !full_v[cur_slot];
  assign step_f = bit_valid && mod_bit && (stage_fine == ST_FINE)   && !full_v[cur_slot];

  updown_seg #(.W(CW)) u_coarse (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_c),
    .dir_up(phase_sig == PH_SIG), .count(cnt_c)
  );

  updown_seg #(.W(FW)) u_fine (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step_f),
    .dir_up(phase_sig == PH_SIG), .count(cnt_f)
  );

  result_combine #(.CW(CW), .FW(FW), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_comb (
    .coarse(cnt_c), .fine(cnt_f), .res(res_s)
  );

  assign result = res_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      ovf_err <= 1'b0;
    end else if (clr) begin
      done    <= 1'b0;
      ovf_err <= 1'b0;
    end else begin
      done <= last_v[slot_of(PH_SIG, ST_FINE)];
      if (|extra_v) ovf_err <= 1'b1;
    end
  end

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bit_valid && stage_fine && phase_sig && !clr));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err && !clr) |=> ovf_err);
  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (result == '0 && !done && !ovf_err));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !clr) |=> $stable(result));
endmodule

// File: tb/sim_dsm_cds_decimator.sv
module sim_dsm_cds_decimator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, bit_valid = 1'b0, mod_bit = 1'b0;
  logic stage_fine = 1'b0, phase_sig = 1'b0;
  logic [11:0] result;
  logic done, ovf_err;

  int tests = 0, fails = 0, done_seen = 0;

  always #5 clk = ~clk;

  dsm_cds_decimator u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_valid(bit_valid),
    .mod_bit(mod_bit), .stage_fine(stage_fine), .phase_sig(phase_sig),
    .result(result), .done(done), .ovf_err(ovf_err)
  );

  always @(negedge clk) if (done) done_seen++;

  // fields: reset-coarse ones, reset-fine ones, signal-coarse ones,
  // signal-fine ones, expected clamped result
  localparam logic [47:0] VEC [10] = '{
    {8'd0,   8'd0,  8'd0,   8'd0,  16'sd0},
    {8'd10,  8'd5,  8'd50,  8'd20, 16'sd1295},
    {8'd100, 8'd30, 8'd20,  8'd2,  -16'sd2048},
    {8'd0,   8'd0,  8'd128, 8'd32, 16'sd2047},
    {8'd64,  8'd16, 8'd64,  8'd16, 16'sd0},
    {8'd3,   8'd31, 8'd4,   8'd0,  16'sd1},
    {8'd0,   8'd0,  8'd63,  8'd31, 16'sd2047},
    {8'd64,  8'd0,  8'd0,   8'd0,  -16'sd2048},
    {8'd64,  8'd1,  8'd0,   8'd0,  -16'sd2048},
    {8'd0,   8'd1,  8'd0,   8'd0,  -16'sd1}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic b, input logic st, input logic ph);
    mod_bit = b; stage_fine = st; phase_sig = ph; bit_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(posedge clk); @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_stage(input int ones, input int total, input logic st, input logic ph);
    for (int i = 0; i < total; i++) push(i < ones, st, ph);
  endtask

  function automatic int sres();
    return int'($signed(result));
  endfunction

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after reset", sres(), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 ovf_err after reset", int'(ovf_err), 0);

    // table of full conversions: R2 R3 R4 R6 R7
    for (int v = 0; v < 10; v++) begin
      do_clear();
      done_seen = 0;
      run_stage(int'(VEC[v][47:40]), 128, 1'b0, 1'b0);
      run_stage(int'(VEC[v][39:32]), 32,  1'b1, 1'b0);
      check("R7 no done before signal fine", done_seen, 0);
      run_stage(int'(VEC[v][31:24]), 128, 1'b0, 1'b1);
      run_stage(int'(VEC[v][23:16]), 32,  1'b1, 1'b1);
      check("R6 result after conversion", sres(), int'($signed(VEC[v][15:0])));
      check("R7 done after last fine bit", int'(done), 1);
      @(negedge clk);
      check("R7 done single pulse", int'(done) + done_seen, 1);
      check("R8 no ovf on legal stream", int'(ovf_err), 0);
    end

    // R2 single coarse signal step
    do_clear();
    push(1'b1, 1'b0, 1'b1);
    check("R2 coarse signal step", sres(), 32);
    // R4 fine signal step
    push(1'b1, 1'b1, 1'b1);
    check("R4 fine signal step", sres(), 33);
    // R3 reset phase steps
    push(1'b1, 1'b1, 1'b0);
    check("R3 fine reset step", sres(), 32);
    push(1'b1, 1'b0, 1'b0);
    check("R3 coarse reset step", sres(), 0);

    // R5 valid low with mod_bit high, then valid zero bits
    do_clear();
    mod_bit = 1'b1; stage_fine = 1'b0; phase_sig = 1'b1; bit_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R5 valid low ignored", sres(), 0);
    run_stage(0, 4, 1'b1, 1'b1);
    check("R5 zero bits ignored", sres(), 0);

    // R8 fine overflow
    do_clear();
    run_stage(32, 32, 1'b1, 1'b0);
    check("R8 ovf low at limit", int'(ovf_err), 0);
    check("R8 count at limit", sres(), -32);
    push(1'b1, 1'b1, 1'b0);
    check("R8 ovf set by extra fine bit", int'(ovf_err), 1);
    check("R8 extra fine bit not counted", sres(), -32);
    repeat (3) @(negedge clk);
    check("R8 ovf sticky", int'(ovf_err), 1);
    // R9 clear drops the flag
    do_clear();
    check("R9 clear drops ovf", int'(ovf_err), 0);
    check("R9 clear zeroes result", sres(), 0);

    // R8 coarse overflow: extra 1 after 128 zeros
    run_stage(0, 128, 1'b0, 1'b1);
    push(1'b1, 1'b0, 1'b1);
    check("R8 ovf set by extra coarse bit", int'(ovf_err), 1);
    check("R8 extra coarse bit not counted", sres(), 0);

    // R9 clear wins over a same-cycle bit
    do_clear();
    push(1'b1, 1'b0, 1'b1);
    clr = 1'b1; mod_bit = 1'b1; stage_fine = 1'b0; phase_sig = 1'b1; bit_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    clr = 1'b0; bit_valid = 1'b0;
    check("R9 clear beats bit", sres(), 0);
    // R9 tallies restart: full 32 fine signal bits again give done
    done_seen = 0;
    run_stage(2, 32, 1'b1, 1'b1);
    check("R9 tally restarted, done fires", int'(done), 1);
    check("R9 fine result after restart", sres(), 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule